// File: doc/BRIEF.md
# Slot Rate Adapter

This block ties together two synchronous domains whose slot periods stand in a whole-number ratio, or close to one. It works on one shared fast clock. Every slot carries a present flag beside its data; a slot with the flag low is an absent slot and carries zero data. The slow input side is paced by a strobe that the block raises on the first fast cycle of each input slot. The source holds its slot steady while that slot lasts.

The input stream goes first through an expander and then through a merger, and the fast stream between them is visible at the ports. The expander turns each input slot into UP_R fast slots. The first fast slot carries the input, and the rest are absent. With STRETCH_S above zero, every STRETCH_S-th input slot gets one extra fast slot, which approximates a ratio that is not a whole number. The merger folds each group of DN_R fast slots into one output slot. The output is the earliest present slot of the group, and any later present slots in that group are lost. A one-cycle drop flag marks each lost slot so that a test can count them. Chaining an expansion by 3 with a merge by 2 gives a 2-to-3 rate change. Setting either factor to 1 leaves only the other stage.

Top module: `rate_bridge`

## Requirements
- R1: `in_stb` is high on the first fast cycle of each input slot and low on the other cycles. An input slot lasts UP_R fast cycles, or UP_R+1 cycles when it is stretched.
- R2: In the cycle after an input slot starts, `mid_valid`/`mid_data` carry the input slot's flag and data. The remaining fast slots of that input slot are absent. An absent fast slot always shows zero data.
- R3: With STRETCH_S > 0, input slots with index S-1, 2S-1, 3S-1 … (counting from 0 after reset) last UP_R+1 fast slots. With STRETCH_S = 0 no slot is stretched.
- R4: The merger closes one group every DN_R fast cycles. In the cycle after each group closes, `out_stb` is high for one cycle and the output slot takes its new value. At all other times the output holds its value.
- R5: An output slot equals the earliest present fast slot of its group. When the whole group is absent, it is absent with zero data.
- R6: In the cycle after the merger samples a present fast slot while an earlier slot of the same group was already present, `out_drop` is high for one cycle. It is low at all other times.
- R7: Synchronous active-high `rst` clears the slot, stretch and group counters and both slot registers. On the first cycle after reset, `in_stb` is high and all outputs are absent with `out_drop` low.
- R8: Over a run of E fast cycles from reset, exactly floor(E/DN_R) output slots are produced. With UP_R = 3 and DN_R = 2, two input slots yield three output slots.
- R9: Elaboration stops if UP_R or DN_R is below 1, or if STRETCH_S is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | output | 1 | High on the first fast cycle of each input slot |
| in_valid | input | 1 | Input slot present flag, held for the slot |
| in_data | input | W | Input slot data, held for the slot |
| mid_valid | output | 1 | Present flag of the expanded fast stream |
| mid_data | output | W | Data of the expanded fast stream |
| out_stb | output | 1 | One-cycle pulse when a new output slot appears |
| out_valid | output | 1 | Output slot present flag |
| out_data | output | W | Output slot data |
| out_drop | output | 1 | One-cycle pulse for a present slot lost in merging |

## Verification
The bench builds three copies of the block with W = 4. The first uses the default 3-up/2-down chain, which covers the 2-to-3 rate and its output count. The second uses UP_R = 1 and DN_R = 3, a pure merge. Its input presence patterns sweep every arrangement of present and absent slots within a three-slot group, which brings the first-present rule and every drop case within reach. The third uses UP_R = 2, DN_R = 1 and STRETCH_S = 3. In that copy, every third slot stretches to three fast cycles while the merger passes slots straight through, so the stretch period can be seen directly at the output.

// File: rtl/rate_pkg.sv
package rate_pkg;
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rate_expand.sv
module rate_expand #(
   parameter int W         = 8,
   parameter int UP_R      = 3,
   parameter int STRETCH_S = 0
) (
   input  logic         clk,
   input  logic         rst,
   output logic         slot_start,
   input  logic         src_valid,
   input  logic [W-1:0] src_data,
   output logic         fast_valid,
   output logic [W-1:0] fast_data
);
   localparam int CW = rate_pkg::cnt_w(UP_R + 2);

   logic [CW-1:0] pos_q;
   logic [CW-1:0] last_pos;
   logic          long_slot;
   logic          slot_end;

   assign slot_start = (pos_q == '0);
   assign last_pos   = long_slot ? CW'(UP_R) : CW'(UP_R - 1);
   assign slot_end   = (pos_q == last_pos);

   generate
      if (STRETCH_S > 0) begin : g_stretch
         localparam int SW = rate_pkg::cnt_w(STRETCH_S);
         logic [SW-1:0] seq_q;
         assign long_slot = (seq_q == SW'(STRETCH_S - 1));
         always_ff @(posedge clk) begin
            if (rst) begin
               seq_q <= '0;
            end else if (slot_end) begin
               seq_q <= long_slot ? '0 : seq_q + 1'b1;
            end
         end
      end else begin : g_plain
         assign long_slot = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q      <= '0;
         fast_valid <= 1'b0;
         fast_data  <= '0;
      end else begin
         pos_q      <= slot_end ? '0 : pos_q + 1'b1;
         fast_valid <= slot_start & src_valid;
         fast_data  <= (slot_start & src_valid) ? src_data : '0;
      end
   end
endmodule

// File: rtl/rate_merge.sv
module rate_merge #(
   parameter int W    = 8,
   parameter int DN_R = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         fast_valid,
   input  logic [W-1:0] fast_data,
   output logic         grp_stb,
   output logic         grp_valid,
   output logic [W-1:0] grp_data,
   output logic         grp_drop
);
   generate
      if (DN_R == 1) begin : g_pass
         always_ff @(posedge clk) begin
            if (rst) begin
               grp_stb   <= 1'b0;
               grp_valid <= 1'b0;
               grp_data  <= '0;
            end else begin
               grp_stb   <= 1'b1;
               grp_valid <= fast_valid;
               grp_data  <= fast_valid ? fast_data : '0;
            end
         end
         assign grp_drop = 1'b0;
      end else begin : g_group
         localparam int DW = rate_pkg::cnt_w(DN_R);
         logic [DW-1:0] idx_q;
         logic          held_v;
         logic [W-1:0]  held_d;
         logic          drop_q;
         logic          closing;

         assign closing  = (idx_q == DW'(DN_R - 1));
         assign grp_drop = drop_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               idx_q     <= '0;
               held_v    <= 1'b0;
               held_d    <= '0;
               drop_q    <= 1'b0;
               grp_stb   <= 1'b0;
               grp_valid <= 1'b0;
               grp_data  <= '0;
            end else begin
               drop_q  <= fast_valid & held_v;
               grp_stb <= closing;
               if (closing) begin
                  idx_q     <= '0;
                  held_v    <= 1'b0;
                  held_d    <= '0;
                  grp_valid <= held_v | fast_valid;
                  grp_data  <= held_v ? held_d : (fast_valid ? fast_data : '0);
               end else begin
                  idx_q <= idx_q + 1'b1;
                  if (!held_v && fast_valid) begin
                     held_v <= 1'b1;
                     held_d <= fast_data;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rate_bridge.sv
module rate_bridge #(
   parameter int W         = 8,
   parameter int UP_R      = 3,
   parameter int DN_R      = 2,
   parameter int STRETCH_S = 0
) (
   input  logic         clk,
   input  logic         rst,
   output logic         in_stb,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         mid_valid,
   output logic [W-1:0] mid_data,
   output logic         out_stb,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         out_drop
);
   // R9: parameter legality
   generate
      if (UP_R < 1) begin : g_bad_up
         $error("rate_bridge: UP_R must be at least 1");
      end
      if (DN_R < 1) begin : g_bad_dn
         $error("rate_bridge: DN_R must be at least 1");
      end
      if (STRETCH_S < 0) begin : g_bad_s
         $error("rate_bridge: STRETCH_S must not be negative");
      end
   endgenerate

   rate_expand #(.W(W), .UP_R(UP_R), .STRETCH_S(STRETCH_S)) u_expand (
      .clk        (clk),
      .rst        (rst),
      .slot_start (in_stb),
      .src_valid  (in_valid),
      .src_data   (in_data),
      .fast_valid (mid_valid),
      .fast_data  (mid_data)
   );

   rate_merge #(.W(W), .DN_R(DN_R)) u_merge (
      .clk        (clk),
      .rst        (rst),
      .fast_valid (mid_valid),
      .fast_data  (mid_data),
      .grp_stb    (out_stb),
      .grp_valid  (out_valid),
      .grp_data   (out_data),
      .grp_drop   (out_drop)
   );
endmodule

// File: rtl/rate_bridge_chk.sv
module rate_bridge_chk #(
   parameter int W    = 8,
   parameter int UP_R = 3,
   parameter int DN_R = 2
) (
   input logic         clk,
   input logic         rst,
   input logic         in_stb,
   input logic         mid_valid,
   input logic [W-1:0] mid_data,
   input logic         out_stb,
   input logic         out_valid,
   input logic [W-1:0] out_data,
   input logic         out_drop
);
   assert_mid_from_start_R2: assert property (@(posedge clk) disable iff (rst)
      mid_valid |-> $past(in_stb));

   assert_absent_zero_R2: assert property (@(posedge clk) disable iff (rst)
      !mid_valid |-> (mid_data == '0));

   assert_out_absent_zero_R5: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (out_data == '0));

   assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !out_stb |-> ($stable(out_valid) && $stable(out_data)));

   assert_drop_needs_slot_R6: assert property (@(posedge clk) disable iff (rst)
      out_drop |-> $past(mid_valid));

   assert_start_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> in_stb);

   generate
      if (UP_R > 1) begin : g_up
         assert_slot_length_R1: assert property (@(posedge clk) disable iff (rst)
            in_stb |=> !in_stb);
      end
      if (DN_R > 1) begin : g_dn
         assert_stb_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            out_stb |=> !out_stb);
      end
   endgenerate
endmodule

bind rate_bridge rate_bridge_chk #(.W(W), .UP_R(UP_R), .DN_R(DN_R)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_stb    (in_stb),
   .mid_valid (mid_valid),
   .mid_data  (mid_data),
   .out_stb   (out_stb),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_drop  (out_drop)
);

// File: tb/sim_rate_bridge.sv
`timescale 1ns/1ps

module ref_lane #(
   parameter int W  = 4,
   parameter int UR = 3,
   parameter int DR = 2,
   parameter int S  = 0,
   parameter int NSLOT = 96
) (
   input  logic         clk,
   output logic         rst,
   input  logic         in_stb,
   output logic         in_valid,
   output logic [W-1:0] in_data,
   input  logic         mid_valid,
   input  logic [W-1:0] mid_data,
   input  logic         out_stb,
   input  logic         out_valid,
   input  logic [W-1:0] out_data,
   input  logic         out_drop,
   output int           nchk,
   output int           nfail,
   output logic         done
);
   bit     xv [0:2047];
   int     xd [0:2047];
   int     xn;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s lane(up=%0d dn=%0d s=%0d) t=%0t actual=%0d expected=%0d",
                  tag, UR, DR, S, $time, act, exp);
      end
   endtask

   initial begin
      int  pos;
      int  k;
      int  e;
      bit  hv;
      int  hd;
      bit  ov;
      int  od;
      int  nout;
      nchk = 0; nfail = 0; done = 1'b0;
      rst = 1'b1; in_valid = 1'b0; in_data = '0;
      xn = 0; pos = 0; k = 0; e = 0;
      hv = 0; hd = 0; ov = 0; od = 0; nout = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R7: state straight after reset
      chk(in_stb == 1'b1, "R7 in_stb", int'(in_stb), 1);
      chk(mid_valid == 1'b0, "R7 mid_valid", int'(mid_valid), 0);
      chk(out_valid == 1'b0 && out_data == '0, "R7 out", int'(out_valid), 0);
      chk(out_drop == 1'b0, "R7 out_drop", int'(out_drop), 0);
      while (k < NSLOT || pos != 0) begin
         if (pos == 0) begin
            int  len;
            bit  v;
            len = (S > 0 && (k % S) == S - 1) ? UR + 1 : UR;
            v   = ((((k / 3) % 8) >> (k % 3)) & 1) != 0;
            in_valid = v;
            in_data  = W'(k % 16);
            // R1: strobe at slot start
            chk(in_stb == 1'b1, "R1 in_stb high", int'(in_stb), 1);
            for (int j = 0; j < len; j++) begin
               xv[xn + j] = (j == 0) ? v : 1'b0;
               xd[xn + j] = (j == 0 && v) ? (k % 16) : 0;
            end
            xn  = xn + len;
            pos = len;
            k++;
         end else begin
            chk(in_stb == 1'b0, (S > 0 && ((k - 1) % S) == S - 1) ? "R3 in_stb low" : "R1 in_stb low",
                int'(in_stb), 0);
         end
         @(posedge clk);
         @(negedge clk);
         // R2: expanded fast slot
         chk(mid_valid == xv[e] && int'(mid_data) == xd[e], "R2 mid slot",
             int'({mid_valid, mid_data}), int'({xv[e], W'(xd[e])}));
         begin
            bit mv;
            int md;
            bit dexp;
            bit sexp;
            mv = (e == 0) ? 1'b0 : xv[e - 1];
            md = (e == 0) ? 0 : xd[e - 1];
            dexp = mv && hv;
            if ((e % DR) == DR - 1) begin
               ov = hv ? 1'b1 : mv;
               od = hv ? hd : (mv ? md : 0);
               hv = 0; hd = 0;
               sexp = 1'b1;
               nout++;
            end else begin
               if (!hv && mv) begin hv = 1; hd = md; end
               sexp = 1'b0;
            end
            chk(out_stb == sexp, "R4 out_stb", int'(out_stb), int'(sexp));
            chk(out_valid == ov && int'(out_data) == od, "R5 out slot",
                int'({out_valid, out_data}), int'({ov, W'(od)}));
            chk(out_drop == dexp, "R6 out_drop", int'(out_drop), int'(dexp));
         end
         pos--;
         e++;
      end
      // R8: output slot count over the run
      chk(nout == e / DR, "R8 output count", nout, e / DR);
      if (UR == 3 && DR == 2)
         chk(nout * 2 == NSLOT * 3, "R8 2-to-3 ratio", nout, NSLOT * 3 / 2);
      done = 1'b1;
   end
endmodule

module sim_rate_bridge;
   localparam int W = 4;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst0, rst1, rst2;
   logic         stb0, stb1, stb2;
   logic         iv0, iv1, iv2;
   logic [W-1:0] id0, id1, id2;
   logic         mv0, mv1, mv2;
   logic [W-1:0] md0, md1, md2;
   logic         os0, os1, os2;
   logic         ov0, ov1, ov2;
   logic [W-1:0] od0, od1, od2;
   logic         dp0, dp1, dp2;
   int           c0, c1, c2, f0, f1, f2;
   logic         d0, d1, d2;

   rate_bridge #(.W(W), .UP_R(3), .DN_R(2), .STRETCH_S(0)) u0 (
      .clk(clk), .rst(rst0), .in_stb(stb0), .in_valid(iv0), .in_data(id0),
      .mid_valid(mv0), .mid_data(md0), .out_stb(os0), .out_valid(ov0),
      .out_data(od0), .out_drop(dp0));
   ref_lane #(.W(W), .UR(3), .DR(2), .S(0)) l0 (
      .clk(clk), .rst(rst0), .in_stb(stb0), .in_valid(iv0), .in_data(id0),
      .mid_valid(mv0), .mid_data(md0), .out_stb(os0), .out_valid(ov0),
      .out_data(od0), .out_drop(dp0), .nchk(c0), .nfail(f0), .done(d0));

   rate_bridge #(.W(W), .UP_R(1), .DN_R(3), .STRETCH_S(0)) u1 (
      .clk(clk), .rst(rst1), .in_stb(stb1), .in_valid(iv1), .in_data(id1),
      .mid_valid(mv1), .mid_data(md1), .out_stb(os1), .out_valid(ov1),
      .out_data(od1), .out_drop(dp1));
   ref_lane #(.W(W), .UR(1), .DR(3), .S(0)) l1 (
      .clk(clk), .rst(rst1), .in_stb(stb1), .in_valid(iv1), .in_data(id1),
      .mid_valid(mv1), .mid_data(md1), .out_stb(os1), .out_valid(ov1),
      .out_data(od1), .out_drop(dp1), .nchk(c1), .nfail(f1), .done(d1));

   rate_bridge #(.W(W), .UP_R(2), .DN_R(1), .STRETCH_S(3)) u2 (
      .clk(clk), .rst(rst2), .in_stb(stb2), .in_valid(iv2), .in_data(id2),
      .mid_valid(mv2), .mid_data(md2), .out_stb(os2), .out_valid(ov2),
      .out_data(od2), .out_drop(dp2));
   ref_lane #(.W(W), .UR(2), .DR(1), .S(3)) l2 (
      .clk(clk), .rst(rst2), .in_stb(stb2), .in_valid(iv2), .in_data(id2),
      .mid_valid(mv2), .mid_data(md2), .out_stb(os2), .out_valid(ov2),
      .out_data(od2), .out_drop(dp2), .nchk(c2), .nfail(f2), .done(d2));

   initial begin
      int cyc;
      int wd_fail;
      cyc = 0; wd_fail = 0;
      @(negedge clk);
      while (!(d0 && d1 && d2) && cyc < 100000) begin
         @(negedge clk);
         cyc++;
      end
      if (!(d0 && d1 && d2)) begin
         wd_fail = 1;
         $display("FAIL watchdog: run stalled after %0d cycles, actual=0 expected=1", cyc);
      end
      $display("== %0d vectors applied, %0d miscompares ==",
               c0 + c1 + c2 + wd_fail, f0 + f1 + f2 + wd_fail);
      $finish;
   end
endmodule